// File: doc/BRIEF.md
# TLB Entry Maintenance Port

This block gives a CPU register-level access to the entries of a small set-associative translation array. Software selects an entry through a select register, stages the high and low words of an entry in two holding registers, and then commits the staged pair to the array. It can also pull an entry back into the holding registers to inspect it. The array keeps two banks of entries, one for instruction translations and one for data translations. The bank is chosen by the support-register bank number that the CPU presents on `bank_sel`.

Writing the high holding register also copies the value into a cause register. A commit is triggered by writing the low holding register. It takes the high word from the cause register and the low word from the write data. In the same cycle as the commit, the block raises an invalidate strobe that carries the page address of the entry being replaced and that entry's old valid bit. Translation lookups use this strobe to drop stale copies. Register reads are combinational. A read made while an array bank is active reloads the holding registers from the selected entry.

Top module: `tlb_access_port`

## Requirements
- R1: Only `bank_sel` values 1 and 2 engage the array. With 0 or 3, a write to register 5 only loads the low holding register, with no commit and no invalidate strobe. A write to register 6 does not touch the cause register (register 7). A read reloads nothing.
- R2: `bank_sel` value N addresses array bank N-1, so entries written under one value are not seen under the other.
- R3: In the select register (register 4, all 32 bits stored), bits [5:4] pick one of 4 sets and bits [3:0] pick one of 16 entries. Higher bits are ignored for addressing.
- R4: A write to register 6 while an array bank is active stores the data both in the high holding register (6) and in the cause register (7).
- R5: A write to register 5 while an array bank is active stores the data in the low holding register. It also writes the selected entry, taking the high word from the cause register and the low word from the write data.
- R6: During a commit, `inv_valid` is high for that cycle only. `inv_page` then equals the replaced entry's high word with bits [12:0] cleared, and `inv_old_valid` equals bit 3 of its low word.
- R7: When `reg_rd` is high and an array bank is active, `reg_rdata` for register 5 or 6 shows the selected entry's low or high word. At that edge both holding registers are reloaded from the entry. With `reg_rd` low, `reg_rdata` shows the holding registers as they are.
- R8: Reset clears all registers and every array entry, so the first commit to any entry reports page 0 with the old valid bit 0.
- R9: Register numbers other than 4 to 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Active support-register bank number |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read strobe (triggers mirror reload) |
| reg_num | input | 4 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| inv_valid | output | 1 | Single-cycle invalidate strobe on commit |
| inv_page | output | 32 | Page address of the replaced entry |
| inv_old_valid | output | 1 | Valid bit of the replaced entry |

## Verification
The bench builds the block with its default parameters: two banks of four sets by sixteen entries, a 13-bit page offset and the valid flag at bit 3. This size puts bank aliasing, neighbouring sets that share an index, and select values with stray upper bits all within reach of a few directed accesses. The replaced-page and old-valid reporting is checked across a fresh entry and an overwritten one.

// File: rtl/tlb_port_pkg.sv
package tlb_port_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [3:0] {
    RN_SELECT = 4'd4,
    RN_LOWORD = 4'd5,
    RN_HIWORD = 4'd6,
    RN_CAUSE  = 4'd7
  } tlb_regnum_e;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } tlb_entry_t;

endpackage

// File: rtl/tlb_port_ctrl.sv
module tlb_port_ctrl
  import tlb_port_pkg::*;
#(
  parameter int unsigned NBANK  = 2,
  parameter int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [1:0]        bank_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_num,
  output logic              tlb_on,
  output logic [BANK_W-1:0] bank_idx,
  output logic              wr_select,
  output logic              wr_loword,
  output logic              wr_hiword,
  output logic              wr_cause,
  output logic              commit,
  output logic              reload
);

  logic [1:0] bank_minus1;

  always_comb begin
    bank_minus1 = bank_sel - 2'd1;
    tlb_on      = (bank_sel != 2'd0) && ({30'd0, bank_sel} <= NBANK);
    bank_idx    = bank_minus1[BANK_W-1:0];

    wr_select   = reg_wr && (reg_num == RN_SELECT);
    wr_loword   = reg_wr && (reg_num == RN_LOWORD);
    wr_hiword   = reg_wr && (reg_num == RN_HIWORD);
    wr_cause    = reg_wr && ((reg_num == RN_CAUSE) ||
                             ((reg_num == RN_HIWORD) && tlb_on));
    commit      = wr_loword && tlb_on;
    reload      = reg_rd && !reg_wr && tlb_on;
  end

endmodule

// File: rtl/tlb_stage_regs.sv
module tlb_stage_regs
  import tlb_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_select,
  input  logic              wr_loword,
  input  logic              wr_hiword,
  input  logic              wr_cause,
  input  logic              reload,
  input  tlb_entry_t        ent_rd,
  output logic [WORD_W-1:0] sel_q,
  output logic [WORD_W-1:0] lo_q,
  output logic [WORD_W-1:0] hi_q,
  output logic [WORD_W-1:0] cause_q
);

  logic [WORD_W-1:0] sel_d, lo_d, hi_d, cause_d;
  logic              sel_en, lo_en, hi_en, cause_en;

  always_comb begin
    sel_en   = wr_select;
    lo_en    = wr_loword || reload;
    hi_en    = wr_hiword || reload;
    cause_en = wr_cause;

    sel_d    = wdata;
    lo_d     = wr_loword ? wdata : ent_rd.lo;
    hi_d     = wr_hiword ? wdata : ent_rd.hi;
    cause_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      cause_q <= '0;
    end else begin
      if (sel_en)   sel_q   <= sel_d;
      if (lo_en)    lo_q    <= lo_d;
      if (hi_en)    hi_q    <= hi_d;
      if (cause_en) cause_q <= cause_d;
    end
  end

  AST_HI_CAUSE_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hiword && wr_cause) |=> (hi_q == $past(wdata)) && (cause_q == $past(wdata))); // R4

  AST_RELOAD_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_loword && !wr_hiword) |=> (lo_q == $past(ent_rd.lo)) && (hi_q == $past(ent_rd.hi))); // R7

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_port_pkg::*;
#(
  parameter int unsigned NENT   = 128,
  parameter int unsigned ADDR_W = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  tlb_entry_t        wentry,
  output tlb_entry_t        rentry
);

  tlb_entry_t mem_q [NENT];

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    logic hit;
    assign hit = we && (addr == ADDR_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[e] <= '0;
      else if (hit) mem_q[e] <= wentry;
    end
  end

  assign rentry = mem_q[addr];

  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem_q[$past(addr)] == $past(wentry))); // R5

endmodule

// File: rtl/tlb_access_port.sv
module tlb_access_port
  import tlb_port_pkg::*;
#(
  parameter int unsigned NBANK      = 2,
  parameter int unsigned NSET       = 4,
  parameter int unsigned NIDX       = 16,
  parameter int unsigned PAGE_SHIFT = 13,
  parameter int unsigned VALID_POS  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bank_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [3:0]        reg_num,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              inv_valid,
  output logic [WORD_W-1:0] inv_page,
  output logic              inv_old_valid
);

  localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int unsigned SET_W  = (NSET  > 1) ? $clog2(NSET)  : 1;
  localparam int unsigned IDX_W  = (NIDX  > 1) ? $clog2(NIDX)  : 1;
  localparam int unsigned ADDR_W = BANK_W + SET_W + IDX_W;
  localparam int unsigned NENT   = 1 << ADDR_W;

  logic              tlb_on, wr_select, wr_loword, wr_hiword, wr_cause, commit, reload;
  logic [BANK_W-1:0] bank_idx;
  logic [WORD_W-1:0] sel_q, lo_q, hi_q, cause_q;
  logic [ADDR_W-1:0] ent_addr;
  tlb_entry_t        ent_rd, ent_wr;

  tlb_port_ctrl #(.NBANK(NBANK), .BANK_W(BANK_W)) u_ctrl (
    .bank_sel (bank_sel),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_num  (reg_num),
    .tlb_on   (tlb_on),
    .bank_idx (bank_idx),
    .wr_select(wr_select),
    .wr_loword(wr_loword),
    .wr_hiword(wr_hiword),
    .wr_cause (wr_cause),
    .commit   (commit),
    .reload   (reload)
  );

  tlb_stage_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (reg_wdata),
    .wr_select(wr_select),
    .wr_loword(wr_loword),
    .wr_hiword(wr_hiword),
    .wr_cause (wr_cause),
    .reload   (reload),
    .ent_rd   (ent_rd),
    .sel_q    (sel_q),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .cause_q  (cause_q)
  );

  always_comb begin
    ent_addr  = {bank_idx, sel_q[IDX_W +: SET_W], sel_q[IDX_W-1:0]};
    ent_wr.hi = cause_q;
    ent_wr.lo = reg_wdata;
  end

  tlb_entry_store #(.NENT(NENT), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (ent_addr),
    .we    (commit),
    .wentry(ent_wr),
    .rentry(ent_rd)
  );

  always_comb begin
    unique case (reg_num)
      RN_SELECT: reg_rdata = sel_q;
      RN_LOWORD: reg_rdata = reload ? ent_rd.lo : lo_q;
      RN_HIWORD: reg_rdata = reload ? ent_rd.hi : hi_q;
      RN_CAUSE:  reg_rdata = cause_q;
      default:   reg_rdata = '0;
    endcase
    inv_valid     = commit;
    inv_page      = {ent_rd.hi[WORD_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    inv_old_valid = ent_rd.lo[VALID_POS];
  end

  AST_NO_RELOAD_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !reg_wr && (bank_sel == 2'd0 || bank_sel == 2'd3)) |=> $stable(hi_q) && $stable(lo_q)); // R1

  AST_INV_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (reg_wr && reg_num == RN_LOWORD)); // R6

  AST_GATED_NO_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_sel == 2'd0 || bank_sel == 2'd3) |-> !inv_valid); // R1

endmodule

// File: tb/tlb_access_port_bench.sv
module tlb_access_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bank_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_num = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        inv_valid;
  logic [31:0] inv_page;
  logic        inv_old_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        s_inv, s_old;
  logic [31:0] s_page, s_rd;

  always #10 clk = ~clk;

  tlb_access_port u_tlb_access_port (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .inv_valid(inv_valid), .inv_page(inv_page),
    .inv_old_valid(inv_old_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input logic [3:0] n, input logic [31:0] d);
    @(negedge clk);
    bank_sel = b; reg_num = n; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    #5;
    s_inv = inv_valid; s_page = inv_page; s_old = inv_old_valid;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] b, input logic [3:0] n);
    @(negedge clk);
    bank_sel = b; reg_num = n; reg_rd = 1'b1; reg_wr = 1'b0;
    #5;
    s_rd = reg_rdata; s_inv = inv_valid;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [3:0] n);
    @(negedge clk);
    reg_num = n; reg_rd = 1'b0; reg_wr = 1'b0;
    #5;
    s_rd = reg_rdata;
  endtask

  task automatic t_reset;
    for (int n = 4; n <= 7; n++) begin
      peek(4'(n));
      chk("R8 reset reg", s_rd, 32'd0);
    end
  endtask

  task automatic t_hi_mirror;
    wr(2'd1, 4'd6, 32'h1234_6008);
    peek(4'd6); chk("R4 hi reg", s_rd, 32'h1234_6008);
    peek(4'd7); chk("R4 cause reg", s_rd, 32'h1234_6008);
  endtask

  task automatic t_commit;
    wr(2'd1, 4'd4, 32'h0000_0025);
    wr(2'd1, 4'd5, 32'h0000_0008);
    chk("R6 inv strobe fresh", {31'd0, s_inv}, 32'd1);
    chk("R8 fresh page zero", s_page, 32'd0);
    chk("R8 fresh old valid", {31'd0, s_old}, 32'd0);
    peek(4'd5); chk("R5 lo reg", s_rd, 32'h0000_0008);
    wr(2'd1, 4'd5, 32'h0000_0011);
    chk("R6 inv strobe overwrite", {31'd0, s_inv}, 32'd1);
    chk("R6 old page", s_page, 32'h1234_6000);
    chk("R6 old valid", {31'd0, s_old}, 32'd1);
    @(negedge clk); #5;
    chk("R6 strobe single cycle", {31'd0, inv_valid}, 32'd0);
  endtask

  task automatic t_reload;
    wr(2'd1, 4'd6, 32'h5555_0000);
    peek(4'd5); chk("R7 no reload without rd", s_rd, 32'h0000_0011);
    rd(2'd1, 4'd5); chk("R7 read shows entry lo", s_rd, 32'h0000_0011);
    peek(4'd6); chk("R5 R7 reloaded hi from cause", s_rd, 32'h1234_6008);
    peek(4'd7); chk("R7 cause untouched", s_rd, 32'h5555_0000);
  endtask

  task automatic t_bank_map;
    rd(2'd2, 4'd6); chk("R2 other bank hi", s_rd, 32'd0);
    peek(4'd5); chk("R2 other bank lo", s_rd, 32'd0);
    rd(2'd1, 4'd5); chk("R2 first bank lo", s_rd, 32'h0000_0011);
  endtask

  task automatic t_fields;
    wr(2'd1, 4'd4, 32'h0000_0015);
    wr(2'd1, 4'd6, 32'h0000_4000);
    wr(2'd1, 4'd5, 32'h0000_0009);
    chk("R3 new slot fresh page", s_page, 32'd0);
    wr(2'd1, 4'd4, 32'h0000_0025);
    rd(2'd1, 4'd5); chk("R3 other set intact", s_rd, 32'h0000_0011);
    wr(2'd1, 4'd4, 32'hFFFF_FF15);
    rd(2'd1, 4'd5); chk("R3 upper bits ignored lo", s_rd, 32'h0000_0009);
    peek(4'd6); chk("R3 upper bits ignored hi", s_rd, 32'h0000_4000);
    peek(4'd4); chk("R3 select stores 32 bits", s_rd, 32'hFFFF_FF15);
  endtask

  task automatic t_gating;
    wr(2'd0, 4'd5, 32'h0000_0077);
    chk("R1 bank0 no strobe", {31'd0, s_inv}, 32'd0);
    peek(4'd5); chk("R1 bank0 lo stored", s_rd, 32'h0000_0077);
    wr(2'd0, 4'd6, 32'hDEAD_0000);
    peek(4'd7); chk("R1 bank0 cause untouched", s_rd, 32'h0000_4000);
    rd(2'd0, 4'd5); chk("R1 bank0 read plain", s_rd, 32'h0000_0077);
    peek(4'd6); chk("R1 bank0 no reload", s_rd, 32'hDEAD_0000);
    wr(2'd3, 4'd5, 32'h0000_0066);
    chk("R1 bank3 no strobe", {31'd0, s_inv}, 32'd0);
    rd(2'd1, 4'd5); chk("R1 array untouched", s_rd, 32'h0000_0009);
  endtask

  task automatic t_unmapped;
    wr(2'd1, 4'd2, 32'hFFFF_FFFF);
    chk("R9 no strobe", {31'd0, s_inv}, 32'd0);
    peek(4'd2); chk("R9 reads zero", s_rd, 32'd0);
    peek(4'd5); chk("R9 lo unchanged", s_rd, 32'h0000_0009);
    peek(4'd7); chk("R9 cause unchanged", s_rd, 32'h0000_4000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hi_mirror();
    t_commit();
    t_reload();
    t_bank_map();
    t_fields();
    t_gating();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule